// File: doc/BRIEF.md
# Masked-Compare Test Vector Sequencer

This block runs a test program against an attached device. The program sits in a word-addressed memory as two areas. The first is a packed array of 4-bit step codes, four per 16-bit control word. The second is a data table. For each step the block reads one step code and streams one to four 64-bit quadwords (four 16-bit words each) from the table to the device. It then takes zero, one or two quadwords back from the device. Each returned quadword that is selected for checking is compared with an expected quadword under a mask quadword, both taken from the table.

A run starts with a pulse on `start`, which loads a step count and two base addresses. The first eight table words are scratch space, so step data begins eight words past `table_base`. Each step that passes decrements the count, and the steps follow one another with no gap. The run ends with a one-cycle `done` pulse. If the count reaches zero, `pass` is high and `result` is zero. If a checked word fails, `pass` is low and `result` holds the count as it stood before the failing step.

Both device ports are valid/ready streams of 16-bit words. On the output stream the block holds `dout_valid` and `dout_data` steady until the device raises `dout_ready`. On the input stream the block raises `din_ready` only when it expects a word, and a word is taken on a cycle where `din_valid` and `din_ready` are both high. The memory port returns `mem_rdata` one cycle after a cycle with `mem_req` high.

Top module: `mcseq_top`

## Requirements
- R1: Out of reset and whenever idle, `busy`, `done`, `mem_req`, `dout_valid` and `din_ready` are all low.
- R2: Bits [3:2] of a step code hold the number of output quadwords minus one. The block sends that many quadwords, word by word in rising address order. The first step starts at `table_base`+8, and each step's data follows directly after the previous step's data.
- R3: While `dout_valid` is high and `dout_ready` is low, `dout_valid` stays high and `dout_data` does not change.
- R4: A checked input word fails when (received XOR expected) AND mask is non-zero. Differences in bit positions where the mask is 0 have no effect.
- R5: Step-code bit 0 checks the first returned quadword and bit 1 checks the second. After the output quadwords, the table holds, for each checked quadword in order, the expected quadword followed by its mask quadword.
- R6: A step code with bit 1 set and bit 0 clear still takes the first returned quadword from the device. That quadword is discarded and has no table entries.
- R7: A step code with bits [1:0] = 00 takes no words from the device.
- R8: When a step fails, the run ends after that step's input has been taken. `done` pulses with `pass` low, and `result` equals the count before the failing step.
- R9: When every step passes, `done` pulses for exactly one cycle after the last step, with `pass` high and `result` zero.
- R10: Step codes are taken from the most significant nibble of a control word downward. After the fourth step code, the next control word is read from the following address, starting from `ctrl_base`.
- R11: `dout_valid` and `din_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that starts a run; ignored while busy |
| step_count | input | 16 | Number of steps to run (must be non-zero) |
| ctrl_base | input | 16 | Word address of the first control word |
| table_base | input | 16 | Word address of the data table, including the 8 scratch words |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |
| dout_valid | output | 1 | Output word valid |
| dout_ready | input | 1 | Device accepts the output word |
| dout_data | output | 16 | Output word |
| din_valid | input | 1 | Device offers an input word |
| din_ready | output | 1 | Block takes the input word |
| din_data | input | 16 | Input word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run reached zero with no mismatch (held until the next start) |
| result | output | 16 | Remaining count at the end of the run (held) |

## Verification
The step count reaching zero and the detection of a mismatch can both occur at the end of the same step. That happens when the last remaining step is the one that fails. The bench sets this up with a one-step run whose second checked quadword mismatches, and with a five-step run that fails at step two. A correct block reports failure with the undecremented count (1 and 4) and does not report a pass. Throughout, the scoreboard checks the exact output word order under device back-pressure, so an extra or missing word in any step shows up as a mismatch.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CREQ, S_CLAT, S_SETUP,
    S_OREQ, S_OLAT, S_OSEND,
    S_EREQ, S_ELAT, S_MREQ, S_MLAT,
    S_IRECV, S_STEPEND
  } seq_state_t;
endpackage

// File: rtl/mcseq_ctrlword.sv
module mcseq_ctrlword #(
  parameter int WORD_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word_in,
  output logic [NIB_W-1:0]  nib,
  output logic              last
);
  localparam int NIBS  = WORD_W / NIB_W;
  localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= word_in;
      idx_q  <= '0;
    end else if (shift) begin
      word_q <= word_q << NIB_W;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign nib  = word_q[WORD_W-1 -: NIB_W];
  assign last = (idx_q == IDX_W'(NIBS - 1));
endmodule

// File: rtl/mcseq_cmp.sv
module mcseq_cmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] rx,
  input  logic [W-1:0] expv,
  input  logic [W-1:0] mask,
  output logic         mism
);
  logic hit;
  assign hit = |((rx ^ expv) & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mism <= 1'b0;
    else if (clr)    mism <= 1'b0;
    else if (en && hit) mism <= 1'b1;
  end
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top
  import mcseq_pkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int ADDR_W        = 16,
  parameter int CNT_W         = 16,
  parameter int QUAD_WORDS    = 4,
  parameter int SCRATCH_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  step_count,
  input  logic [ADDR_W-1:0] ctrl_base,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [WORD_W-1:0] dout_data,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [WORD_W-1:0] din_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CNT_W-1:0]  result
);
  localparam int WI_W = $clog2(QUAD_WORDS);
  localparam logic [WI_W-1:0] WI_LAST = WI_W'(QUAD_WORDS - 1);
  localparam logic [ADDR_W-1:0] QSTEP = ADDR_W'(QUAD_WORDS);
  localparam logic [ADDR_W-1:0] CSTEP = ADDR_W'(2 * QUAD_WORDS);

  seq_state_t state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] cptr, tptr;
  logic [WI_W-1:0]   wi;
  logic [1:0]        oq;
  logic              iq;
  logic [WORD_W-1:0] obuf, ebuf, mbuf;
  logic [3:0]        nib;
  logic              nib_last, mism, cur_chk;
  logic              cw_load, cw_shift, cmp_clr, cmp_en;

  mcseq_ctrlword #(.WORD_W(WORD_W), .NIB_W(4)) u_cw (
    .clk(clk), .rst_n(rst_n), .load(cw_load), .shift(cw_shift),
    .word_in(mem_rdata), .nib(nib), .last(nib_last));

  mcseq_cmp #(.W(WORD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .en(cmp_en),
    .rx(din_data), .expv(ebuf), .mask(mbuf), .mism(mism));

  assign cur_chk    = iq ? nib[1] : nib[0];
  assign cw_load    = (state == S_CLAT);
  assign cw_shift   = (state == S_STEPEND) && !mism && (cnt != 1) && !nib_last;
  assign cmp_clr    = (state == S_SETUP);
  assign cmp_en     = (state == S_IRECV) && din_valid && cur_chk;
  assign dout_valid = (state == S_OSEND);
  assign dout_data  = obuf;
  assign din_ready  = (state == S_IRECV);
  assign busy       = (state != S_IDLE);

  always_comb begin
    mem_req  = 1'b1;
    mem_addr = tptr + ADDR_W'(wi);
    case (state)
      S_CREQ:          mem_addr = cptr;
      S_OREQ, S_EREQ:  mem_addr = tptr + ADDR_W'(wi);
      S_MREQ:          mem_addr = tptr + QSTEP + ADDR_W'(wi);
      default:         mem_req  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      cptr   <= '0;
      tptr   <= '0;
      wi     <= '0;
      oq     <= '0;
      iq     <= 1'b0;
      obuf   <= '0;
      ebuf   <= '0;
      mbuf   <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cnt   <= step_count;
          cptr  <= ctrl_base;
          tptr  <= table_base + ADDR_W'(SCRATCH_WORDS);
          state <= S_CREQ;
        end
        S_CREQ:  state <= S_CLAT;
        S_CLAT:  state <= S_SETUP;
        S_SETUP: begin
          oq    <= nib[3:2];
          wi    <= '0;
          iq    <= 1'b0;
          state <= S_OREQ;
        end
        S_OREQ:  state <= S_OLAT;
        S_OLAT: begin
          obuf  <= mem_rdata;
          state <= S_OSEND;
        end
        S_OSEND: if (dout_ready) begin
          if (wi == WI_LAST) begin
            wi   <= '0;
            tptr <= tptr + QSTEP;
            if (oq != 0) begin
              oq    <= oq - 1'b1;
              state <= S_OREQ;
            end else if (nib[0])  state <= S_EREQ;
            else if (nib[1])      state <= S_IRECV;
            else                  state <= S_STEPEND;
          end else begin
            wi    <= wi + 1'b1;
            state <= S_OREQ;
          end
        end
        S_EREQ:  state <= S_ELAT;
        S_ELAT: begin
          ebuf  <= mem_rdata;
          state <= S_MREQ;
        end
        S_MREQ:  state <= S_MLAT;
        S_MLAT: begin
          mbuf  <= mem_rdata;
          state <= S_IRECV;
        end
        S_IRECV: if (din_valid) begin
          if (wi == WI_LAST) begin
            wi <= '0;
            if (cur_chk) tptr <= tptr + CSTEP;
            if (!iq && nib[1]) begin
              iq    <= 1'b1;
              state <= S_EREQ;
            end else state <= S_STEPEND;
          end else begin
            wi    <= wi + 1'b1;
            state <= cur_chk ? S_EREQ : S_IRECV;
          end
        end
        S_STEPEND: begin
          if (mism) begin
            done   <= 1'b1;
            pass   <= 1'b0;
            result <= cnt;
            state  <= S_IDLE;
          end else if (cnt == 1) begin
            cnt    <= '0;
            done   <= 1'b1;
            pass   <= 1'b1;
            result <= '0;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
            if (nib_last) begin
              cptr  <= cptr + 1'b1;
              state <= S_CREQ;
            end else state <= S_SETUP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcseq_checks.sv
module mcseq_checks #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [CNT_W-1:0]  result,
  input logic              mem_req,
  input logic              dout_valid,
  input logic              dout_ready,
  input logic [WORD_W-1:0] dout_data,
  input logic              din_ready
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !dout_valid && !din_ready))
    else $error("R1 idle outputs active");

  p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)))
    else $error("R3 output dropped under back-pressure");

  p_fail_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> (result != 0))
    else $error("R8 failure reported with zero count");

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("R9 done longer than one cycle");

  p_pass_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (result == 0))
    else $error("R9 pass with non-zero result");

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_valid && din_ready))
    else $error("R11 both directions active");
endmodule

bind mcseq_top mcseq_checks #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass(pass),
  .result(result), .mem_req(mem_req), .dout_valid(dout_valid),
  .dout_ready(dout_ready), .dout_data(dout_data), .din_ready(din_ready));

// File: tb/mcseq_top_tb.sv
module mcseq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] step_count = '0, ctrl_base = '0, table_base = '0;
  logic mem_req, dout_valid, din_ready, busy, done, pass;
  logic [15:0] mem_addr, dout_data, result;
  logic [15:0] mem_rdata = '0;
  logic dout_ready = 1'b0, din_valid = 1'b0;
  logic [15:0] din_data = '0;

  always #4 clk = ~clk;

  mcseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .step_count(step_count),
    .ctrl_base(ctrl_base), .table_base(table_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .busy(busy), .done(done), .pass(pass), .result(result));

  logic [15:0] mem [1024];
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[9:0]];

  int total = 0, bad = 0, cyc = 0;
  int rdy_cnt = 0, overlap = 0;
  bit bp = 0;
  logic [15:0] exp_q[$];
  logic [15:0] in_q[$];
  logic [3:0]  nib_q[$];
  int tp = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver side of the device and output monitor (scoreboard)
  always @(negedge clk) begin
    cyc++;
    dout_ready = bp ? ((cyc % 3) != 0) : 1'b1;
    din_valid  = (in_q.size() > 0) && ((cyc % 4) != 1);
    din_data   = (in_q.size() > 0) ? in_q[0] : 16'h0;
    #1;
    if (dout_valid && dout_ready) begin
      if (exp_q.size() == 0) check(0, "R2 extra output word", dout_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(dout_data == e, "R2/R3 output word", dout_data, e);
      end
    end
    if (din_valid && din_ready) void'(in_q.pop_front());
    if (din_ready) rdy_cnt++;
    if (dout_valid && din_ready) overlap++;
  end

  function automatic logic [15:0] qw(input logic [15:0] seed, input int k);
    return seed + 16'(k) * 16'h1111;
  endfunction

  task automatic out_quad(input logic [15:0] seed);
    for (int k = 0; k < 4; k++) begin
      mem[tp + k] = qw(seed, k);
      exp_q.push_back(qw(seed, k));
    end
    tp += 4;
  endtask

  task automatic chk_quad(input logic [15:0] seed, input logic [15:0] flip, input logic [15:0] mask);
    for (int k = 0; k < 4; k++) begin
      mem[tp + k]     = qw(seed, k);
      mem[tp + 4 + k] = mask;
      in_q.push_back(qw(seed, k) ^ flip);
    end
    tp += 8;
  endtask

  task automatic step(input logic [3:0] nib, input logic [15:0] os,
                      input logic [15:0] s1, input logic [15:0] f1, input logic [15:0] m1,
                      input logic [15:0] s2, input logic [15:0] f2, input logic [15:0] m2);
    nib_q.push_back(nib);
    for (int q = 0; q <= int'(nib[3:2]); q++) out_quad(os + 16'(q) * 16'h0101);
    if (nib[0]) chk_quad(s1, f1, m1);
    else if (nib[1]) for (int k = 0; k < 4; k++) in_q.push_back(16'hDEAD ^ 16'(k));
    if (nib[1]) chk_quad(s2, f2, m2);
  endtask

  task automatic begin_prog(input int tb_base);
    exp_q.delete(); in_q.delete(); nib_q.delete();
    tp = tb_base + 8;
    table_base = 16'(tb_base);
  endtask

  task automatic run(input int cbase, input int cnt, input bit exp_pass,
                     input int exp_res, input string tag);
    int w;
    for (int i = 0; i < 4; i++) mem[cbase + i] = 16'h0;
    foreach (nib_q[i]) mem[cbase + i/4] = mem[cbase + i/4] | (16'(nib_q[i]) << (12 - 4*(i%4)));
    ctrl_base = 16'(cbase);
    step_count = 16'(cnt);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    check(w < 5000, {tag, " watchdog"}, w, 0);
    check(pass == exp_pass, {tag, " pass"}, pass, exp_pass);
    check(result == 16'(exp_res), {tag, " result"}, result, exp_res);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", done, 0);
    check(exp_q.size() == 0, {tag, " output words left"}, exp_q.size(), 0);
    check(in_q.size() == 0, {tag, " input words left"}, in_q.size(), 0);
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !mem_req && !dout_valid && !din_ready, "R1 reset outputs",
          {busy, done, mem_req, dout_valid, din_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);

    // R2 R7: one step, one output quad, no input
    begin_prog(100);
    step(4'h0, 16'h1000, 0, 0, 0, 0, 0, 0);
    rdy_cnt = 0;
    run(10, 1, 1, 0, "R2");
    check(rdy_cnt == 0, "R7 no input taken", rdy_cnt, 0);

    // R3 R4 R5 R6: four mixed steps under back-pressure
    bp = 1;
    begin_prog(200);
    step(4'hC, 16'h2000, 0, 0, 0, 0, 0, 0);
    step(4'h1, 16'h3000, 16'h4000, 16'h00F0, 16'hFF0F, 0, 0, 0);   // R4 masked-off flip
    step(4'h6, 16'h5000, 0, 0, 0, 16'h6000, 0, 16'hFFFF);           // R6 discard first
    step(4'hB, 16'h7000, 16'h8000, 0, 16'hFFFF, 16'h9000, 0, 16'hFFFF); // R5 both
    run(20, 4, 1, 0, "R5");
    check(in_q.size() == 0, "R6 discarded quad consumed", in_q.size(), 0);

    // R10: six steps over two control words
    bp = 0;
    begin_prog(400);
    step(4'h0, 16'h1100, 0, 0, 0, 0, 0, 0);
    step(4'h1, 16'h1200, 16'h1300, 0, 16'hFFFF, 0, 0, 0);
    step(4'h4, 16'h1400, 0, 0, 0, 0, 0, 0);
    step(4'h2, 16'h1500, 0, 0, 0, 16'h1600, 0, 16'hFFFF);
    step(4'h3, 16'h1700, 16'h1800, 0, 16'hFFFF, 16'h1900, 0, 16'hFFFF);
    step(4'hC, 16'h1A00, 0, 0, 0, 0, 0, 0);
    run(30, 6, 1, 0, "R10");

    // R8: failure at step two of five
    bp = 1;
    begin_prog(600);
    step(4'h1, 16'h2100, 16'h2200, 0, 16'hFFFF, 0, 0, 0);
    step(4'h5, 16'h2300, 16'h2400, 16'h0100, 16'hFFFF, 0, 0, 0);
    run(40, 5, 0, 4, "R8");

    // R8 with count reaching its last step: final step fails on second quad
    begin_prog(700);
    step(4'h3, 16'h2500, 16'h2600, 0, 16'hFFFF, 16'h2700, 16'h8000, 16'h8000);
    run(50, 1, 0, 1, "R8 last step");

    check(overlap == 0, "R11 output and input overlap", overlap, 0);
    check(!busy, "R1 idle at end", busy, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule